// File: doc/BRIEF.md
# Two-Wire Bus Software Line Driver

This block lets software run a two-wire serial bus (I2C) one bit at a time through a small register-bus slave. It holds the present levels of the clock line and the data line. Software changes them by writing masks: one register raises the lines whose mask bit is 1, and a second register lowers them. Zero bits in either mask leave the matching line as it is. A read of the raise register returns both levels, so software can see the bus it is driving.

The block also tells a byte-level protocol engine what the bus is doing. It finds bus conditions in the software write itself, not by sampling pins. Lowering data while the clock is high is a START. Raising data while the clock is high is a STOP. Any write that raises the clock is one clock-rise step. Each of these is a registered pulse one cycle wide. When the engine must answer on the data line, for an acknowledge or a transmitted bit, it loads a data level with a one-cycle strobe, and that strobe wins over any software write in the same cycle.

The slave decodes a 4 KB window. Pads, open-drain modelling and the byte engine live outside the block.

Top module: `i2cbb_regif`

## Requirements
- R1: While reset is asserted and after it is released, both line outputs are 1 and all three event pulses are 0.
- R2: A write to offset 0x000 (raise register) sets the clock line to 1 when data bit 0 is 1 and sets the data line to 1 when data bit 1 is 1. A zero bit keeps that line's level. The new level appears on the first clock edge that samples the write.
- R3: A write to offset 0x004 (lower register) clears the clock line to 0 when data bit 0 is 1 and clears the data line to 0 when data bit 1 is 1. A zero bit keeps that line's level.
- R4: A read of offset 0x000 returns the data line in bit 1, the clock line in bit 0, and zero in bits 7..2. Read data is combinational from the address.
- R5: A START pulse follows a write to offset 0x004 with bit 1 set when the clock line was 1 before that write.
- R6: A STOP pulse follows a write to offset 0x004's partner, offset 0x000, with bit 1 set when the clock line was 1 before that write.
- R7: A clock-rise pulse follows every write to offset 0x000 with bit 0 set, unless the same write raises STOP. A write to offset 0x004 never raises it.
- R8: Event pulses are registered, appear in the cycle after the write is sampled, and last exactly one cycle. At most one event is high in any cycle.
- R9: A write to any offset other than 0x000 and 0x004 changes neither line and raises no event. A read of any offset other than 0x000 returns 0.
- R10: When the engine load strobe is 1, the data line takes the engine's value on that edge, whatever register write arrives in the same cycle. The clock line still follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for bus_addr |
| eng_sda_load | input | 1 | Engine strobe that loads the data line |
| eng_sda_val | input | 1 | Level loaded by the engine |
| scl_o | output | 1 | Present clock-line level |
| sda_o | output | 1 | Present data-line level |
| start_o | output | 1 | START pulse |
| stop_o | output | 1 | STOP pulse |
| clk_rise_o | output | 1 | Clock-rise pulse |

## Verification
The bench sets every one of the four line states. From each, it writes all 256 data bytes to both registers, so it covers writes that raise the clock and data together. A design that tests START or STOP against the updated clock level would miss conditions here, or report false ones. A design that lets the clock rise fire next to STOP would show two pulses at once. The bench also sweeps the whole window with all-ones writes and reads, which catches a decoder that looks at too few address bits and aliases the registers. Last, it drives the engine strobe against opposing writes: if the register write won, the data line would be wrong while the clock line still moved.

// File: rtl/i2cbb_pkg.sv
package i2cbb_pkg;
  localparam int LINE_SCL  = 0;
  localparam int LINE_SDA  = 1;
  localparam int NUM_LINES = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_RAISE = 2'd1,
    ACC_LOWER = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
  } bus_evt_t;
endpackage

// File: rtl/i2cbb_addr_dec.sv
module i2cbb_addr_dec
  import i2cbb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int RAISE_OFS = 0,
  parameter int LOWER_OFS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output acc_kind_e         kind,
  output logic              rd_raise
);
  localparam logic [ADDR_W-1:0] RaiseAddr = ADDR_W'(RAISE_OFS);
  localparam logic [ADDR_W-1:0] LowerAddr = ADDR_W'(LOWER_OFS);

  always_comb begin
    kind = ACC_NONE;
    if (wr) begin
      if (addr == RaiseAddr)      kind = ACC_RAISE;
      else if (addr == LowerAddr) kind = ACC_LOWER;
    end
  end

  assign rd_raise = (addr == RaiseAddr);
endmodule

// File: rtl/i2cbb_line_reg.sv
module i2cbb_line_reg
  import i2cbb_pkg::*;
#(
  parameter int N_LINES  = NUM_LINES,
  parameter int OVR_LINE = LINE_SDA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  acc_kind_e          kind,
  input  logic [N_LINES-1:0] mask,
  input  logic               ovr_load,
  input  logic               ovr_val,
  output logic [N_LINES-1:0] lines_q
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic nxt;
    logic en;

    always_comb begin
      nxt = lines_q[i];
      en  = 1'b0;
      if (kind == ACC_RAISE && mask[i]) begin
        nxt = 1'b1;
        en  = 1'b1;
      end else if (kind == ACC_LOWER && mask[i]) begin
        nxt = 1'b0;
        en  = 1'b1;
      end
      if (i == OVR_LINE && ovr_load) begin
        nxt = ovr_val;
        en  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lines_q[i] <= 1'b1;
      else if (en) lines_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/i2cbb_evt_dec.sv
module i2cbb_evt_dec
  import i2cbb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  acc_kind_e kind,
  input  logic      scl_bit,
  input  logic      sda_bit,
  input  logic      scl_now,
  output bus_evt_t  evt_q
);
  bus_evt_t evt_d;

  always_comb begin
    evt_d.start = (kind == ACC_LOWER) && sda_bit && scl_now;
    evt_d.stop  = (kind == ACC_RAISE) && sda_bit && scl_now;
    evt_d.rise  = (kind == ACC_RAISE) && scl_bit && !evt_d.stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end
endmodule

// File: rtl/i2cbb_regif.sv
module i2cbb_regif
  import i2cbb_pkg::*;
#(
  parameter int WIN_BYTES = 4096,
  parameter int DATA_W    = 8,
  parameter int RAISE_OFS = 0,
  parameter int LOWER_OFS = 4,
  localparam int ADDR_W   = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_sda_load,
  input  logic              eng_sda_val,
  output logic              scl_o,
  output logic              sda_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              clk_rise_o
);
  acc_kind_e            kind;
  logic                 rd_raise;
  logic [NUM_LINES-1:0] lines;
  bus_evt_t             evt;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_LINES];

  i2cbb_addr_dec #(
    .ADDR_W(ADDR_W), .RAISE_OFS(RAISE_OFS), .LOWER_OFS(LOWER_OFS)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .kind(kind), .rd_raise(rd_raise)
  );

  i2cbb_line_reg #(
    .N_LINES(NUM_LINES), .OVR_LINE(LINE_SDA)
  ) u_lines (
    .clk(clk), .rst_n(rst_n), .kind(kind),
    .mask(bus_wdata[NUM_LINES-1:0]),
    .ovr_load(eng_sda_load), .ovr_val(eng_sda_val),
    .lines_q(lines)
  );

  i2cbb_evt_dec u_evt (
    .clk(clk), .rst_n(rst_n), .kind(kind),
    .scl_bit(bus_wdata[LINE_SCL]), .sda_bit(bus_wdata[LINE_SDA]),
    .scl_now(lines[LINE_SCL]), .evt_q(evt)
  );

  assign scl_o      = lines[LINE_SCL];
  assign sda_o      = lines[LINE_SDA];
  assign start_o    = evt.start;
  assign stop_o     = evt.stop;
  assign clk_rise_o = evt.rise;
  assign bus_rdata  = rd_raise ? {{(DATA_W-NUM_LINES){1'b0}}, lines} : '0;

  assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, clk_rise_o}));

  assert_start_needs_clk_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(rst_n) && $past(scl_o) && !scl_o || $past(rst_n) && $past(scl_o));

  assert_stop_needs_clk_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> $past(scl_o));

  assert_rise_leaves_clk_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rise_o |-> scl_o);

  assert_engine_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(eng_sda_load) |-> sda_o == $past(eng_sda_val));

  assert_idle_keeps_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) && !$past(eng_sda_load) |-> $stable(scl_o) && $stable(sda_o));

  assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> !start_o && !stop_o && !clk_rise_o);
endmodule

// File: tb/i2cbb_regif_tb_top.sv
`timescale 1ns/1ps
module i2cbb_regif_tb_top;
  localparam logic [11:0] RAISE = 12'h000;
  localparam logic [11:0] LOWER = 12'h004;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        eng_sda_load, eng_sda_val;
  logic        scl_o, sda_o, start_o, stop_o, clk_rise_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic m_scl, m_sda;

  always #2.5 clk = ~clk;

  i2cbb_regif dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_sda_load(eng_sda_load), .eng_sda_val(eng_sda_val),
    .scl_o(scl_o), .sda_o(sda_o), .start_o(start_o), .stop_o(stop_o),
    .clk_rise_o(clk_rise_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one write cycle; returns after the edge, inputs idle again
  task automatic wr_cyc(input logic [11:0] a, input logic [7:0] d,
                        input bit ld, input bit lv);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    eng_sda_load = ld; eng_sda_val = lv;
    @(negedge clk);
    bus_wr = 1'b0; eng_sda_load = 1'b0; bus_addr = RAISE;
    #0.5;
  endtask

  task automatic put_state(input logic s, input logic d);
    wr_cyc(LOWER, 8'h03, 0, 0);
    wr_cyc(RAISE, {6'b0, d, 1'b0}, 0, 0);
    wr_cyc(RAISE, {7'b0, s}, 0, 0);
    m_scl = s; m_sda = d;
  endtask

  task automatic check_all(input string req, input bit e_st, input bit e_sp, input bit e_ri);
    chk(scl_o == m_scl, {req, " clock line"}, scl_o, m_scl);
    chk(sda_o == m_sda, {req, " data line"}, sda_o, m_sda);
    chk({start_o, stop_o, clk_rise_o} == {e_st, e_sp, e_ri},
        {req, " events start/stop/rise"}, {start_o, stop_o, clk_rise_o}, {e_st, e_sp, e_ri});
    chk(bus_rdata == {6'b0, m_sda, m_scl}, "R4 readback", bus_rdata, {m_sda, m_scl});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = RAISE; bus_wr = 1'b0; bus_wdata = 8'h00;
    eng_sda_load = 1'b0; eng_sda_val = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_o && sda_o, "R1 reset levels", {sda_o, scl_o}, 3);
    chk(!start_o && !stop_o && !clk_rise_o, "R1 reset events", {start_o, stop_o, clk_rise_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(scl_o && sda_o && bus_rdata == 8'h03, "R1 after release", bus_rdata, 3);

    // full sweep: each start state, both registers, every byte
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 2; r++) begin
        for (int d = 0; d < 256; d++) begin
          bit e_st, e_sp, e_ri;
          logic [7:0] db;
          db = 8'(d);
          put_state(s[0], s[1]);
          e_st = 0; e_sp = 0; e_ri = 0;
          if (r == 0) begin
            e_sp = m_scl & db[1];
            e_ri = db[0] & !e_sp;
            m_scl = m_scl | db[0];
            m_sda = m_sda | db[1];
            wr_cyc(RAISE, db, 0, 0);
            check_all("R2 R6 R7", e_st, e_sp, e_ri);
          end else begin
            e_st = m_scl & db[1];
            m_scl = m_scl & ~db[0];
            m_sda = m_sda & ~db[1];
            wr_cyc(LOWER, db, 0, 0);
            check_all("R3 R5 R7", e_st, e_sp, e_ri);
          end
          @(negedge clk); #0.5;
          chk(!start_o && !stop_o && !clk_rise_o, "R8 pulse width",
              {start_o, stop_o, clk_rise_o}, 0);
        end
      end
    end

    // lower register reads as zero
    @(negedge clk); bus_addr = LOWER; #0.5;
    chk(bus_rdata == 8'h00, "R9 read lower offset", bus_rdata, 0);

    // every other offset: all-ones write from state 0/0 has no effect
    put_state(0, 0);
    for (int a = 0; a < 4096; a++) begin
      if (a == 0 || a == 4) continue;
      wr_cyc(12'(a), 8'hFF, 0, 0);
      bus_addr = 12'(a); #0.5;
      chk(bus_rdata == 8'h00, "R9 read other offset", bus_rdata, 0);
      chk(!scl_o && !sda_o && !start_o && !stop_o && !clk_rise_o, "R9 write ignored",
          {scl_o, sda_o, start_o, stop_o, clk_rise_o}, 0);
    end

    // engine load precedence
    put_state(1, 1);
    wr_cyc(12'h010, 8'h00, 1, 0);
    m_sda = 0;
    check_all("R10 load alone", 0, 0, 0);
    wr_cyc(LOWER, 8'h03, 1, 1);
    m_scl = 0; m_sda = 1;
    check_all("R10 load beats lower", 1, 0, 0);
    wr_cyc(RAISE, 8'h03, 1, 0);
    m_scl = 1; m_sda = 0;
    check_all("R10 load beats raise", 0, 0, 1);

    done = 1;
    report();
  end
endmodule